// File: doc/BRIEF.md
# Ternary-Weight Threshold Gate

This block computes a single threshold neuron over `N` binary inputs. Each input has a weight of -1, 0 or +1, stored as a 2-bit code. The gate also has one signed bias. The weighted sum is formed without any multiplier. The block counts the set inputs whose weight is +1 and the set inputs whose weight is -1. It subtracts the second count from the first and adds the bias. The gate fires when that total is zero or above.

Weights and the bias are written one at a time through a small write port. One address exists per weight, and address `N` holds the bias. The firing decision is always present combinationally on `fire_comb`. A registered copy is also produced: `fire_q` is captured whenever `in_valid` is high, and `out_valid` marks it one cycle later. This suits either a purely combinational use or a pipelined one.

Top module: `tern_gate`

## Requirements
- R1: A weight code of 2'b01 makes its input count +1 toward the sum when that input is 1.
- R2: A weight code of 2'b11 makes its input count -1 toward the sum when that input is 1.
- R3: Weight codes 2'b00 and 2'b10 (reserved) contribute nothing, whatever the input value.
- R4: `fire_comb` is 1 exactly when (count of +1 active) - (count of -1 active) + bias >= 0. A total of 0 fires and a total of -1 does not.
- R5: A write with `wr_addr == N` loads `wr_data` as the two's-complement bias of $clog2(N)+2 bits. A write with `wr_addr == k < N` loads `wr_data[1:0]` as the code of weight k.
- R6: A write with `wr_addr > N` changes neither any weight nor the bias.
- R7: When `in_valid` is high at a clock edge, `out_valid` is 1 after that edge and `fire_q` equals the decision for the inputs of that cycle. When `in_valid` is low, `out_valid` is 0 after the edge and `fire_q` keeps its value.
- R8: After reset all weights are 0, the bias is 0, and `out_valid` and `fire_q` are 0.
- R9: A configuration write takes effect on `fire_comb` right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | $clog2(N+1) | Weight index 0..N-1, or N for the bias |
| wr_data | input | $clog2(N)+2 | Bias value, or the weight code in bits [1:0] |
| in_bits | input | N | Binary gate inputs |
| in_valid | input | 1 | Capture the decision into the output register |
| fire_comb | output | 1 | Combinational firing decision |
| fire_q | output | 1 | Registered firing decision |
| out_valid | output | 1 | `fire_q` was updated on the last edge |

## Verification
A corrupted weight code or bias shows up in the same cycle on `fire_comb`. It appears only for the input patterns whose total crosses zero because of the fault. For that reason, every one of the 2^N patterns is swept for each stored configuration. Totals of exactly 0 and -1 are included to expose off-by-one threshold faults. A faulty write decode becomes visible one edge after the write, as a changed decision for a pattern chosen to be sensitive to that weight or to the bias. A broken output stage shows on `out_valid` or `fire_q` one edge after the `in_valid` cycle.

// File: rtl/tern_gate.sv
module tern_gate #(
  parameter int N = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N+1)-1:0]     wr_addr,
  input  logic [$clog2(N)+1:0]       wr_data,
  input  logic [N-1:0]               in_bits,
  input  logic                       in_valid,
  output logic                       fire_comb,
  output logic                       fire_q,
  output logic                       out_valid
);
  localparam int AW = $clog2(N+1);
  localparam int BW = $clog2(N) + 2;
  localparam int CW = $clog2(N+1);
  localparam int SW = BW + 2;

  logic [1:0]        wt_q [N];
  logic [BW-1:0]     bias_q;
  logic [N-1:0]      pos_hit, neg_hit;
  logic [CW-1:0]     pos_cnt, neg_cnt;
  logic signed [SW-1:0] total;

  for (genvar i = 0; i < N; i++) begin : g_wt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wt_q[i] <= 2'b00;
      else if (wr_en && wr_addr == AW'(i)) wt_q[i] <= wr_data[1:0];

    assign pos_hit[i] = in_bits[i] && (wt_q[i] == 2'b01);
    assign neg_hit[i] = in_bits[i] && (wt_q[i] == 2'b11);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bias_q <= '0;
    else if (wr_en && wr_addr == AW'(N)) bias_q <= wr_data;

  always_comb begin
    pos_cnt = '0;
    neg_cnt = '0;
    for (int i = 0; i < N; i++) begin
      pos_cnt = pos_cnt + CW'(pos_hit[i]);
      neg_cnt = neg_cnt + CW'(neg_hit[i]);
    end
  end

  assign total = $signed({{(SW-BW){bias_q[BW-1]}}, bias_q})
               + $signed({{(SW-CW){1'b0}}, pos_cnt})
               - $signed({{(SW-CW){1'b0}}, neg_cnt});
  assign fire_comb = ~total[SW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fire_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) fire_q <= fire_comb;
    end

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(fire_q)));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (fire_q == $past(fire_comb)));
  // R4
  bias_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bits == '0) |-> (fire_comb == !bias_q[BW-1]));
  // R5
  bias_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(N)) |=> (bias_q == $past(wr_data)));
  // R6
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > AW'(N)) |=> $stable(bias_q));
endmodule

// File: tb/tern_gate_test.sv
module tern_gate_test;
  localparam int N  = 8;
  localparam int AW = $clog2(N+1);
  localparam int BW = $clog2(N) + 2;

  logic clk = 0, rst_n = 0, wr_en = 0, in_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [N-1:0]  in_bits = '0;
  logic fire_comb, fire_q, out_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  tern_gate #(.N(N)) uut (.*);

  always #5 clk = ~clk;

  localparam logic [2*N+BW-1:0] CFG [6] = '{
    {16'h5555, 5'h1C},
    {16'hFFFF, 5'h03},
    {16'h0000, 5'h1F},
    {16'hAAAA, 5'h00},
    {16'h7D1C, 5'h00},
    {16'hD7B4, 5'h1E}
  };

  function automatic bit model(input logic [2*N-1:0] w, input logic [BW-1:0] b,
                               input logic [N-1:0] x);
    int s = $signed(b);
    for (int i = 0; i < N; i++) begin
      if (x[i] && w[2*i +: 2] == 2'b01) s++;
      if (x[i] && w[2*i +: 2] == 2'b11) s--;
    end
    return s >= 0;
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(input logic [2*N-1:0] w, input logic [BW-1:0] b);
    for (int i = 0; i < N; i++) wr(i, {{(BW-2){1'b0}}, w[2*i +: 2]});
    wr(N, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    in_bits = '1;
    #12 rst_n = 1;
    @(negedge clk);
    // R8: zero weights and bias give total 0, so the gate fires
    check(out_valid, 1'b0, "R8 out_valid after reset");
    check(fire_q, 1'b0, "R8 fire_q after reset");
    check(fire_comb, 1'b1, "R8 zero config fires");

    // R1 R2 R3 R4: exhaustive sweep per configuration
    foreach (CFG[k]) begin
      logic [2*N-1:0] w = CFG[k][2*N+BW-1:BW];
      logic [BW-1:0]  b = CFG[k][BW-1:0];
      int bad = 0;
      logic [N-1:0] first = '0;
      load(w, b);
      for (int x = 0; x < (1 << N); x++) begin
        in_bits = N'(x);
        #1;
        if (fire_comb !== model(w, b, N'(x))) begin
          if (bad == 0) first = N'(x);
          bad++;
        end
      end
      in_bits = first;
      #1;
      check(fire_comb, model(w, b, first), $sformatf("R1 R2 R3 R4 cfg%0d sweep", k));
    end

    // R4: boundary totals 0 and -1
    load(16'h5555, 5'h18);
    in_bits = 8'hFF; #1;
    check(fire_comb, 1'b1, "R4 total zero fires");
    in_bits = 8'h7F; #1;
    check(fire_comb, 1'b0, "R4 total minus one quiet");

    // R5: extreme biases
    load(16'hFFFF, 5'h0F);
    in_bits = 8'hFF; #1;
    check(fire_comb, 1'b1, "R5 bias +15 vs eight -1");
    wr(N, 5'h10);
    in_bits = 8'h00; #1;
    check(fire_comb, 1'b0, "R5 bias -16 alone");

    // R6: out-of-range write leaves config untouched
    load(16'h0000, 5'h00);
    wr(12, 5'h13);
    wr(15, 5'h13);
    in_bits = 8'hFF; #1;
    check(fire_comb, 1'b1, "R6 writes above N ignored");

    // R9: new weight visible right after the capturing edge
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd3; wr_data = 5'h03;
    @(posedge clk); #1;
    wr_en = 0;
    in_bits = 8'h08; #1;
    check(fire_comb, 1'b0, "R9 weight live after edge");

    // R7: registered output stage
    load(16'h5555, 5'h1C);
    @(negedge clk);
    in_bits = 8'h0F; in_valid = 1;
    @(negedge clk);
    check(out_valid, 1'b1, "R7 out_valid follows in_valid");
    check(fire_q, 1'b1, "R7 fire_q captured");
    in_bits = 8'h03; in_valid = 0;
    @(negedge clk);
    check(out_valid, 1'b0, "R7 out_valid drops");
    check(fire_q, 1'b1, "R7 fire_q holds when idle");
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(fire_q, 1'b0, "R7 fire_q new capture");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule